// File: doc/BRIEF.md
# UART Channel Command Controller

This block sits between a host CPU's register write path and one UART channel. Each host write delivers a command byte. The byte carries three things: an encoded miscellaneous command, a lock flag, and two enable bits, one for the transmitter and one for the receiver. The controller keeps the enable state of both directions. It reports transmitter readiness and emptiness, and it issues the one-clock strobes that the shifters, FIFOs and status logic of the channel act on.

The two directions stop in different ways. Turning the receiver off takes effect at once, and any character that is partly received is lost. Turning the transmitter off sends the transmitter into a draining phase. In that phase the character in the shifter and everything still queued finish sending, and only then does the transmitter become inactive. The lock flag lets software issue a command without tracking the enable state. When the lock is set, the enable bits of the byte are ignored.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: A host write is the cycle in which `wr_en` is 1 at a rising clock edge. The byte is decoded as follows: bits 7:3 are the command code, bit 2 is the lock flag, bit 1 is the transmitter enable and bit 0 is the receiver enable. Every registered output shows the effect of the write in the cycle after that edge.
- R2: On a write with bit 2 = 1, bits 1:0 are ignored, and `rx_en`, `tx_rdy` and `tx_active` keep their values except where a reset command (R9, R10) or the end of a drain (R4) changes them.
- R3: A write with lock 0 and bit 1 = 1 makes `tx_rdy` = 1 and `tx_active` = 1. `tx_emt` is 1 exactly when `tx_rdy` is 1, `tx_busy` is 0 and `tx_fifo_nempty` is 0.
- R4: A write with lock 0 and bit 1 = 0 clears `tx_rdy` and `tx_emt`. If `tx_busy` or `tx_fifo_nempty` is 1 at that edge, `tx_active` stays 1 until the first edge at which both are 0, and then falls. Otherwise it falls at once.
- R5: A write with lock 0 and bit 1 = 1 during draining restores `tx_rdy` = 1 directly, and `tx_active` never drops.
- R6: A write with lock 0 and bit 0 = 1 (and no receiver reset) sets `rx_en` and gives a one-cycle `rx_restart` pulse. The pulse is given even if `rx_en` was already 1.
- R7: A write with lock 0 and bit 0 = 0 clears `rx_en` in the next cycle and gives no `rx_restart` pulse.
- R8: Code 00000, reserved code 00001 and codes 00110 to 11111 produce no strobe.
- R9: Code 00010 gives a one-cycle `rx_reset_p` pulse and forces `rx_en` to 0 with no `rx_restart`, whatever bits 2:0 hold.
- R10: Code 00011 gives a one-cycle `tx_reset_p` pulse and makes the transmitter inactive in the next cycle (`tx_active` = `tx_rdy` = 0). This happens even while draining, and whatever bits 2:0 hold.
- R11: Code 00100 gives a one-cycle `err_clr_p` pulse, which clears the break, parity, framing and overrun status bits.
- R12: Code 00101 gives a one-cycle `brk_clr_p` pulse, which clears the break-change interrupt bit.
- R13: Strobes appear only in the cycle after a write, and at most one of the four command strobes is high at a time. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command byte |
| wr_data | input | 8 | Command byte |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_fifo_nempty | input | 1 | Transmit FIFO holds at least one character |
| rx_en | output | 1 | Receiver enabled |
| tx_active | output | 1 | Transmitter running (enabled or draining) |
| tx_rdy | output | 1 | Transmitter enabled and accepting characters |
| tx_emt | output | 1 | Transmitter enabled and fully empty |
| rx_restart | output | 1 | Pulse: receiver returns to start-bit search |
| rx_reset_p | output | 1 | Pulse: receiver and receive FIFO reset |
| tx_reset_p | output | 1 | Pulse: transmitter reset |
| err_clr_p | output | 1 | Pulse: clear received error status |
| brk_clr_p | output | 1 | Pulse: clear break-change interrupt |

## Verification
The checker tests several invariants on every cycle. It confirms that readiness implies activity, that emptiness implies readiness, and that at most one command strobe is high. It confirms that a strobe never follows a cycle without a write, that a reset strobe coincides with the disabled state, that a lock write holds the enables, and that a drain with work pending keeps the transmitter active. Some behaviour only the bench scenarios can show. This includes the exact cycle at which a drain completes, re-enabling in the middle of a drain, reset commands overriding enable bits in the same byte, and the per-code strobe mapping. The bench checks these against its own model, using directed sequences and seeded random traffic.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

   typedef enum logic [1:0] {
      TXS_OFF   = 2'd0,
      TXS_ON    = 2'd1,
      TXS_DRAIN = 2'd2
   } tx_state_e;

   // command codes whose position in the strobe vector follows their value
   localparam int unsigned CODE_FIRST_STROBE = 2;
   localparam int unsigned NUM_STROBES       = 4;
   localparam int unsigned IDX_RX_RST        = 0;
   localparam int unsigned IDX_TX_RST        = 1;
   localparam int unsigned IDX_ERR_CLR       = 2;
   localparam int unsigned IDX_BRK_CLR       = 3;

   typedef struct packed {
      logic lock;
      logic tx_on;
      logic rx_on;
   } ctrl_bits_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
   import uart_cmd_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CMD_W    = 5,
   parameter int unsigned LOCK_BIT = 2,
   parameter int unsigned TXEN_BIT = 1,
   parameter int unsigned RXEN_BIT = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [DATA_W-1:0]      wr_data,
   output ctrl_bits_t             ctrl,
   output logic [NUM_STROBES-1:0] hit,
   output logic [NUM_STROBES-1:0] strobe_q
);
   localparam int unsigned CMD_LSB = DATA_W - CMD_W;

   logic [CMD_W-1:0] code;

   assign code       = wr_data[DATA_W-1:CMD_LSB];
   assign ctrl.lock  = wr_data[LOCK_BIT];
   assign ctrl.tx_on = wr_data[TXEN_BIT];
   assign ctrl.rx_on = wr_data[RXEN_BIT];

   for (genvar i = 0; i < NUM_STROBES; i++) begin : g_hit
      localparam logic [CMD_W-1:0] MATCH = CMD_W'(CODE_FIRST_STROBE + i);
      assign hit[i] = wr_en && (code == MATCH);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) strobe_q[i] <= 1'b0;
         else        strobe_q[i] <= hit[i];
      end
   end

endmodule

// File: rtl/uart_cmd_tx_ctrl.sv
module uart_cmd_tx_ctrl
   import uart_cmd_pkg::*;
#(
   parameter bit GRACEFUL_OFF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_en,
   input  logic en_bit,
   input  logic rst_hit,
   input  logic tx_busy,
   input  logic tx_fifo_nempty,
   output logic tx_active,
   output logic tx_rdy,
   output logic tx_emt
);
   tx_state_e state_q, state_d, off_target;
   logic      pending;

   assign pending = tx_busy | tx_fifo_nempty;

   if (GRACEFUL_OFF) begin : g_drain
      assign off_target = pending ? TXS_DRAIN : TXS_OFF;
   end else begin : g_abrupt
      assign off_target = TXS_OFF;
   end

   always_comb begin
      state_d = state_q;
      if (rst_hit) begin
         state_d = TXS_OFF;
      end else if (upd_en) begin
         if (en_bit)                 state_d = TXS_ON;
         else if (state_q == TXS_OFF) state_d = TXS_OFF;
         else                         state_d = off_target;
      end else if (state_q == TXS_DRAIN && !pending) begin
         state_d = TXS_OFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TXS_OFF;
      else        state_q <= state_d;
   end

   assign tx_rdy    = (state_q == TXS_ON);
   assign tx_active = (state_q != TXS_OFF);
   assign tx_emt    = tx_rdy && !pending;

endmodule

// File: rtl/uart_cmd_rx_ctrl.sv
module uart_cmd_rx_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_en,
   input  logic en_bit,
   input  logic rst_hit,
   output logic rx_en,
   output logic rx_restart
);
   logic en_d, restart_d;

   always_comb begin
      en_d      = rx_en;
      restart_d = 1'b0;
      if (rst_hit) begin
         en_d = 1'b0;
      end else if (upd_en) begin
         en_d      = en_bit;
         restart_d = en_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en      <= 1'b0;
         rx_restart <= 1'b0;
      end else begin
         rx_en      <= en_d;
         rx_restart <= restart_d;
      end
   end

endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
   import uart_cmd_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CMD_W        = 5,
   parameter int unsigned LOCK_BIT     = 2,
   parameter int unsigned TXEN_BIT     = 1,
   parameter int unsigned RXEN_BIT     = 0,
   parameter bit          GRACEFUL_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_busy,
   input  logic              tx_fifo_nempty,
   output logic              rx_en,
   output logic              tx_active,
   output logic              tx_rdy,
   output logic              tx_emt,
   output logic              rx_restart,
   output logic              rx_reset_p,
   output logic              tx_reset_p,
   output logic              err_clr_p,
   output logic              brk_clr_p
);
   if (DATA_W != CMD_W + 3) begin : g_bad_width
      $error("uart_cmd_ctrl: DATA_W must equal CMD_W + 3");
   end
   if (LOCK_BIT == TXEN_BIT || LOCK_BIT == RXEN_BIT || TXEN_BIT == RXEN_BIT) begin : g_bad_bits
      $error("uart_cmd_ctrl: control bit positions must differ");
   end
   if (LOCK_BIT >= DATA_W - CMD_W || TXEN_BIT >= DATA_W - CMD_W ||
       RXEN_BIT >= DATA_W - CMD_W) begin : g_bad_pos
      $error("uart_cmd_ctrl: control bits must lie below the command field");
   end
   if ((1 << CMD_W) < CODE_FIRST_STROBE + NUM_STROBES) begin : g_bad_cmd
      $error("uart_cmd_ctrl: command field too narrow for strobe codes");
   end

   ctrl_bits_t             ctrl;
   logic [NUM_STROBES-1:0] hit, strobe_q;
   logic                   upd_en;

   uart_cmd_decode #(
      .DATA_W   (DATA_W),
      .CMD_W    (CMD_W),
      .LOCK_BIT (LOCK_BIT),
      .TXEN_BIT (TXEN_BIT),
      .RXEN_BIT (RXEN_BIT)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ctrl     (ctrl),
      .hit      (hit),
      .strobe_q (strobe_q)
   );

   assign upd_en = wr_en && !ctrl.lock;

   uart_cmd_tx_ctrl #(
      .GRACEFUL_OFF (GRACEFUL_OFF)
   ) u_tx (
      .clk            (clk),
      .rst_n          (rst_n),
      .upd_en         (upd_en),
      .en_bit         (ctrl.tx_on),
      .rst_hit        (hit[IDX_TX_RST]),
      .tx_busy        (tx_busy),
      .tx_fifo_nempty (tx_fifo_nempty),
      .tx_active      (tx_active),
      .tx_rdy         (tx_rdy),
      .tx_emt         (tx_emt)
   );

   uart_cmd_rx_ctrl u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_en     (upd_en),
      .en_bit     (ctrl.rx_on),
      .rst_hit    (hit[IDX_RX_RST]),
      .rx_en      (rx_en),
      .rx_restart (rx_restart)
   );

   assign rx_reset_p = strobe_q[IDX_RX_RST];
   assign tx_reset_p = strobe_q[IDX_TX_RST];
   assign err_clr_p  = strobe_q[IDX_ERR_CLR];
   assign brk_clr_p  = strobe_q[IDX_BRK_CLR];

endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       tx_busy,
   input logic       tx_fifo_nempty,
   input logic       rx_en,
   input logic       tx_active,
   input logic       tx_rdy,
   input logic       tx_emt,
   input logic       rx_restart,
   input logic       rx_reset_p,
   input logic       tx_reset_p,
   input logic       err_clr_p,
   input logic       brk_clr_p
);
   logic any_strobe;
   assign any_strobe = rx_reset_p | tx_reset_p | err_clr_p | brk_clr_p | rx_restart;

   AST_LOCK_HOLDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[2] && wr_data[7:3] != 5'd2) |=> (rx_en == $past(rx_en))) // R2
      else $error("AST_LOCK_HOLDS_RX");
   AST_LOCK_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[2] && wr_data[7:3] != 5'd3 && tx_rdy) |=> tx_rdy) // R2
      else $error("AST_LOCK_HOLDS_TX");
   AST_EMT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_emt |-> (tx_rdy && !tx_busy && !tx_fifo_nempty)) // R3
      else $error("AST_EMT_NEEDS_RDY");
   AST_RDY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rdy |-> tx_active) // R4
      else $error("AST_RDY_NEEDS_ACTIVE");
   AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && !tx_rdy && (tx_busy || tx_fifo_nempty) &&
       !(wr_en && wr_data[7:3] == 5'd3)) |=> tx_active) // R4
      else $error("AST_DRAIN_HOLDS");
   AST_RESTART_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      rx_restart |-> rx_en) // R6
      else $error("AST_RESTART_ENABLES");
   AST_RXRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset_p |-> (!rx_en && !rx_restart)) // R9
      else $error("AST_RXRST_OFF");
   AST_TXRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset_p |-> !tx_active) // R10
      else $error("AST_TXRST_OFF");
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_reset_p, tx_reset_p, err_clr_p, brk_clr_p})) // R13
      else $error("AST_STROBE_ONEHOT");
   AST_NO_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !any_strobe) // R13
      else $error("AST_NO_WRITE_NO_STROBE");

endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_data        (wr_data),
   .tx_busy        (tx_busy),
   .tx_fifo_nempty (tx_fifo_nempty),
   .rx_en          (rx_en),
   .tx_active      (tx_active),
   .tx_rdy         (tx_rdy),
   .tx_emt         (tx_emt),
   .rx_restart     (rx_restart),
   .rx_reset_p     (rx_reset_p),
   .tx_reset_p     (tx_reset_p),
   .err_clr_p      (err_clr_p),
   .brk_clr_p      (brk_clr_p)
);

// File: tb/uart_cmd_ctrl_tb_top.sv
module uart_cmd_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tx_busy = 1'b0;
   logic       tx_fifo_nempty = 1'b0;
   logic       rx_en, tx_active, tx_rdy, tx_emt, rx_restart;
   logic       rx_reset_p, tx_reset_p, err_clr_p, brk_clr_p;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // bench model: tx state 0 off, 1 on, 2 draining
   int  m_tx = 0;
   bit  m_rx = 1'b0;
   bit  m_restart, m_rxrst, m_txrst, m_err, m_brk;

   always #10 clk = ~clk;

   uart_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_busy(tx_busy), .tx_fifo_nempty(tx_fifo_nempty),
      .rx_en(rx_en), .tx_active(tx_active), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
      .rx_restart(rx_restart), .rx_reset_p(rx_reset_p), .tx_reset_p(tx_reset_p),
      .err_clr_p(err_clr_p), .brk_clr_p(brk_clr_p)
   );

   function automatic int next_tx(int cur, bit w, logic [7:0] d, bit pend);
      if (w && d[7:3] == 5'd3) return 0;          // R10
      if (w && !d[2]) begin                      // R1 R2
         if (d[1]) return 1;                     // R3 R5
         if (cur == 0) return 0;
         return pend ? 2 : 0;                    // R4
      end
      if (cur == 2 && !pend) return 0;           // R4
      return cur;
   endfunction

   task automatic chk(string tag, string nm, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", tag, nm, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 R6 R7 R9", "rx_en", rx_en, m_rx);
      chk("R4 R5 R10", "tx_active", tx_active, m_tx != 0);
      chk("R3 R4 R5", "tx_rdy", tx_rdy, m_tx == 1);
      chk("R3", "tx_emt", tx_emt, m_tx == 1 && !tx_busy && !tx_fifo_nempty);
      chk("R6 R7", "rx_restart", rx_restart, m_restart);
      chk("R9 R8 R13", "rx_reset_p", rx_reset_p, m_rxrst);
      chk("R10 R8 R13", "tx_reset_p", tx_reset_p, m_txrst);
      chk("R11 R8 R13", "err_clr_p", err_clr_p, m_err);
      chk("R12 R8 R13", "brk_clr_p", brk_clr_p, m_brk);
   endtask

   task automatic step(bit w, logic [7:0] d, bit b, bit n);
      bit pend;
      @(negedge clk);
      wr_en = w; wr_data = d; tx_busy = b; tx_fifo_nempty = n;
      pend = b | n;
      @(posedge clk);
      m_tx      = next_tx(m_tx, w, d, pend);
      m_restart = w && !d[2] && d[0] && d[7:3] != 5'd2;
      if (w && d[7:3] == 5'd2)  m_rx = 1'b0;
      else if (w && !d[2])      m_rx = d[0];
      m_rxrst = w && d[7:3] == 5'd2;
      m_txrst = w && d[7:3] == 5'd3;
      m_err   = w && d[7:3] == 5'd4;
      m_brk   = w && d[7:3] == 5'd5;
      #1;
      compare_all();
   endtask

   function automatic logic [7:0] cmd(int code, bit lk, bit te, bit re);
      return {code[4:0], lk, te, re};
   endfunction

   initial begin : watchdog
      while (!done && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_1234));
      m_restart = 0; m_rxrst = 0; m_txrst = 0; m_err = 0; m_brk = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare_all();                               // R13 reset state

      // R3 R6: enable both, idle line -> empty
      step(1, cmd(0, 0, 1, 1), 0, 0);
      step(0, 8'h00, 0, 0);
      // R2: lock write with enables 00 keeps both on
      step(1, cmd(0, 1, 0, 0), 0, 0);
      // R8: reserved and unused codes give no strobe
      step(1, cmd(1, 1, 0, 0), 0, 0);
      step(1, cmd(7, 1, 0, 0), 0, 0);
      step(1, cmd(31, 1, 0, 0), 0, 0);
      // R4: disable tx while busy -> draining
      step(1, cmd(0, 0, 0, 1), 1, 1);
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 0, 1);
      // R5: re-enable during drain
      step(1, cmd(0, 0, 1, 1), 0, 1);
      // R4: disable again, finish drain
      step(1, cmd(0, 0, 0, 1), 1, 0);
      step(0, 8'h00, 0, 0);
      step(0, 8'h00, 0, 0);
      // R10: tx reset during drain with enable bit set
      step(1, cmd(0, 0, 1, 1), 0, 0);
      step(1, cmd(0, 0, 0, 1), 1, 1);
      step(1, cmd(3, 0, 1, 1), 1, 1);
      step(0, 8'h00, 1, 1);
      // R9: rx reset overrides bit0
      step(1, cmd(2, 0, 1, 1), 0, 0);
      // R7: rx disable
      step(1, cmd(0, 0, 1, 1), 0, 0);
      step(1, cmd(0, 0, 1, 0), 0, 0);
      // R11 R12 back to back, R13 strobe falls after
      step(1, cmd(4, 1, 0, 0), 0, 0);
      step(1, cmd(5, 1, 0, 0), 0, 0);
      step(0, 8'h00, 0, 0);

      // seeded random traffic
      for (int i = 0; i < 3000; i++) begin
         bit          w;
         logic [7:0]  d;
         w = ($urandom % 3) == 0;
         d = $urandom;
         if (($urandom % 4) != 0) d[7:3] = 5'($urandom % 7);
         step(w, d, ($urandom % 3) == 0, ($urandom % 3) == 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule